// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block is the front of a scalar in-order pipeline. It keeps the program counter, drives it onto the address port of an instruction memory, and hands the fetched word to the decode stage. The memory is synchronous and returns the addressed 32-bit word one cycle after the address is presented. In the cycle that read is in progress, the unit works out the following program counter. By default that is the current value plus the 4-byte instruction size. A later stage can override it with a redirect and a target address when a taken branch, a jump or an exception changes the flow.

The unit has two stages. The request stage tracks which address is in flight in the memory. The output stage pairs the returned word with its address and a valid bit. A stall freezes both stages and the program counter. While stalled, the unit re-presents the in-flight address so that the word already returned stays correct. A redirect overrides a stall. It discards the wrong-path request that is in flight and loads a NOP bubble into the output stage.

Top module: `fetch_npc_unit`

## Requirements
- R1: While rst_ni is low, and before the first clock edge after its release, if_valid_o is 0 and imem_addr_o equals the reset address 0x00000000.
- R2: In a cycle with neither stall nor redirect, imem_addr_o after the edge equals imem_addr_o before the edge plus 4.
- R3: Each output with if_valid_o = 1 carries in if_instr_o the memory word at the address in if_pc_o. The first such output appears after the second clock edge following reset release.
- R4: At an edge where stall_i = 1 and redirect_i = 0, if_instr_o, if_pc_o and if_valid_o keep their values.
- R5: Valid outputs follow consecutive addresses 4 apart, with none skipped and none repeated, across any pattern of stalls, up to the next redirect.
- R6: After an edge with redirect_i = 1, the PC equals redirect_pc_i with bits [1:0] cleared. imem_addr_o shows that value when stall_i is low.
- R7: The redirect edge and the following non-stalled edge each leave if_valid_o = 0 with if_instr_o = NOP_INSTR (default 0x00000000). The next valid output is the redirect target.
- R8: When redirect_i and stall_i are both 1, the redirect takes effect exactly as it would without the stall.
- R9: imem_addr_o[1:0] is always 0. Bits [1:0] of redirect_pc_i have no effect on any address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Freeze the PC and both fetch stages |
| redirect_i | input | 1 | Replace the sequential next PC with redirect_pc_i |
| redirect_pc_i | input | ADDR_W | Redirect target address |
| imem_addr_o | output | ADDR_W | Instruction memory read address |
| imem_rdata_i | input | INSTR_W | Word returned one cycle after the address |
| if_instr_o | output | INSTR_W | Fetched instruction to decode |
| if_pc_o | output | ADDR_W | Address of if_instr_o |
| if_valid_o | output | 1 | if_instr_o holds a real instruction, not a bubble |

## Verification
The bench sweeps every combination of stall and redirect over three-cycle windows. This covers stalls right after a redirect, back-to-back redirects, and redirects during a stall. Each window's target has different low bits, which tests whether the unit ignores them. Every memory word is a known function of its address, so a wrong pairing of word and address shows up at once. Tracking the expected address of each valid output separates a lost or duplicated fetch after a stall from a late or early bubble after a redirect.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned INSTR_BYTES = 4;
  localparam int unsigned ALIGN_BITS  = $clog2(INSTR_BYTES);

  typedef enum logic [1:0] {
    NPC_SEQ   = 2'd0,
    NPC_HOLD  = 2'd1,
    NPC_REDIR = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/fetch_npc_sel.sv
module fetch_npc_sel
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              stall_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output npc_sel_e          sel_o,
  output logic [ADDR_W-1:0] npc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] tgt_aligned;

  always_comb tgt_aligned = {target_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  // redirect outranks stall
  always_comb begin
    if (redirect_i)   sel_o = NPC_REDIR;
    else if (stall_i) sel_o = NPC_HOLD;
    else              sel_o = NPC_SEQ;
  end

  always_comb begin
    case (sel_o)
      NPC_REDIR: npc_o = tgt_aligned;
      NPC_HOLD:  npc_o = pc_i;
      default:   npc_o = pc_i + STEP;
    endcase
  end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
  import fetch_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  npc_sel_e          sel_i,
  input  logic [ADDR_W-1:0] npc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] req_pc_o,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] pc_q, req_pc_q;
  logic              req_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= RESET_PC;
      req_pc_q    <= RESET_PC;
      req_valid_q <= 1'b0;
    end else begin
      case (sel_i)
        NPC_REDIR: begin
          pc_q        <= npc_i;
          req_pc_q    <= pc_q;
          req_valid_q <= 1'b0;  // wrong-path fetch
        end
        NPC_SEQ: begin
          pc_q        <= npc_i;
          req_pc_q    <= pc_q;
          req_valid_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // stalled: re-read the in-flight address so the returned word stays put
  always_comb addr_o = (sel_i == NPC_HOLD) ? req_pc_q : pc_q;

  assign pc_o        = pc_q;
  assign req_pc_o    = req_pc_q;
  assign req_valid_o = req_valid_q;
endmodule

// File: rtl/fetch_out_reg.sv
module fetch_out_reg
  import fetch_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        INSTR_W   = 32,
  parameter logic [INSTR_W-1:0] NOP_INSTR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  npc_sel_e           sel_i,
  input  logic [INSTR_W-1:0] rdata_i,
  input  logic [ADDR_W-1:0]  req_pc_i,
  input  logic               req_valid_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic               valid_o
);
  logic [INSTR_W-1:0] instr_q;
  logic [ADDR_W-1:0]  pc_q;
  logic               valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q <= NOP_INSTR;
      pc_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      case (sel_i)
        NPC_REDIR: begin
          instr_q <= NOP_INSTR;
          valid_q <= 1'b0;
        end
        NPC_SEQ: begin
          instr_q <= req_valid_i ? rdata_i : NOP_INSTR;
          pc_q    <= req_pc_i;
          valid_q <= req_valid_i;
        end
        default: ;
      endcase
    end
  end

  assign instr_o = instr_q;
  assign pc_o    = pc_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fetch_npc_unit.sv
module fetch_npc_unit
  import fetch_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        INSTR_W   = 32,
  parameter logic [ADDR_W-1:0]  RESET_PC  = '0,
  parameter logic [INSTR_W-1:0] NOP_INSTR = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic               redirect_i,
  input  logic [ADDR_W-1:0]  redirect_pc_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic [INSTR_W-1:0] if_instr_o,
  output logic [ADDR_W-1:0]  if_pc_o,
  output logic               if_valid_o
);
  npc_sel_e          sel;
  logic [ADDR_W-1:0] pc, npc, req_pc;
  logic              req_valid;

  fetch_npc_sel #(.ADDR_W(ADDR_W)) u_sel (
    .pc_i      (pc),
    .stall_i   (stall_i),
    .redirect_i(redirect_i),
    .target_i  (redirect_pc_i),
    .sel_o     (sel),
    .npc_o     (npc)
  );

  fetch_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .npc_i      (npc),
    .pc_o       (pc),
    .req_pc_o   (req_pc),
    .req_valid_o(req_valid),
    .addr_o     (imem_addr_o)
  );

  fetch_out_reg #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .NOP_INSTR(NOP_INSTR)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .rdata_i    (imem_rdata_i),
    .req_pc_i   (req_pc),
    .req_valid_i(req_valid),
    .instr_o    (if_instr_o),
    .pc_o       (if_pc_o),
    .valid_o    (if_valid_o)
  );
endmodule

// File: rtl/fetch_npc_unit_chk.sv
module fetch_npc_unit_chk
  import fetch_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        INSTR_W   = 32,
  parameter logic [INSTR_W-1:0] NOP_INSTR = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stall_i,
  input logic               redirect_i,
  input logic [ADDR_W-1:0]  redirect_pc_i,
  input logic [ADDR_W-1:0]  imem_addr_o,
  input logic [INSTR_W-1:0] if_instr_o,
  input logic [ADDR_W-1:0]  if_pc_o,
  input logic               if_valid_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !redirect_i) ##1 !stall_i |-> imem_addr_o == $past(imem_addr_o) + STEP);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !redirect_i) |=> $stable(if_instr_o) && $stable(if_pc_o) && $stable(if_valid_o));

  // R6
  redirect_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i ##1 !stall_i |->
      imem_addr_o == {$past(redirect_pc_i[ADDR_W-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}});

  // R7, R8
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !if_valid_o && if_instr_o == NOP_INSTR);

  // R9
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_o[ALIGN_BITS-1:0] == '0);
endmodule

bind fetch_npc_unit fetch_npc_unit_chk #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .NOP_INSTR(NOP_INSTR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .redirect_i   (redirect_i),
  .redirect_pc_i(redirect_pc_i),
  .imem_addr_o  (imem_addr_o),
  .if_instr_o   (if_instr_o),
  .if_pc_o      (if_pc_o),
  .if_valid_o   (if_valid_o)
);

// File: tb/fetch_npc_unit_test.sv
`timescale 1ns/1ps
module fetch_npc_unit_test;
  localparam logic [31:0] NOP = 32'h0000_0000;
  localparam logic [31:0] ALIGN_MASK = 32'hFFFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        redir = 1'b0;
  logic [31:0] tgt = '0;
  logic [31:0] addr, rdata, instr, pc;
  logic        valid;

  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [31:0] exp_pc, exp_fetch;
  int          bubble_left;
  logic [31:0] h_instr, h_pc;
  logic        h_valid;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return a ^ 32'hC3C3_0001;  // never equals NOP for aligned a
  endfunction

  initial rdata = '0;
  always @(posedge clk) rdata <= word_of(addr);

  fetch_npc_unit uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .stall_i      (stall),
    .redirect_i   (redir),
    .redirect_pc_i(tgt),
    .imem_addr_o  (addr),
    .imem_rdata_i (rdata),
    .if_instr_o   (instr),
    .if_pc_o      (pc),
    .if_valid_o   (valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic rd, input logic [31:0] tg);
    stall = st; redir = rd; tgt = tg;
    @(posedge clk);
    @(negedge clk);
    if (rd) begin
      chk(!valid, st ? "R8 bubble valid" : "R7 bubble valid", {31'b0, valid}, 32'h0);
      chk(instr == NOP, "R7 bubble nop", instr, NOP);
      exp_pc = tg & ALIGN_MASK;
      bubble_left = 1;
    end else if (st) begin
      chk(instr == h_instr, "R4 instr hold", instr, h_instr);
      chk(pc == h_pc, "R4 pc hold", pc, h_pc);
      chk(valid == h_valid, "R4 valid hold", {31'b0, valid}, {31'b0, h_valid});
    end else if (bubble_left > 0) begin
      chk(!valid, "R7 second bubble", {31'b0, valid}, 32'h0);
      bubble_left--;
    end else begin
      chk(valid, "R3 valid", {31'b0, valid}, 32'h1);
      chk(pc == exp_pc, "R5 sequence", pc, exp_pc);
      chk(instr == word_of(exp_pc), "R3 pairing", instr, word_of(exp_pc));
      exp_pc += 32'd4;
    end
    if (rd) exp_fetch = tg & ALIGN_MASK;
    else if (!st) exp_fetch += 32'd4;
    if (rd) chk(addr == exp_fetch, st ? "R8 redirect addr" : "R6 redirect addr", addr, exp_fetch);
    else if (!st) chk(addr == exp_fetch, "R2 addr step", addr, exp_fetch);
    chk(addr[1:0] == 2'b00, "R9 align", addr, addr & ALIGN_MASK);
    h_instr = instr; h_pc = pc; h_valid = valid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid, "R1 reset valid", {31'b0, valid}, 32'h0);
    chk(addr == 32'h0, "R1 reset addr", addr, 32'h0);
    rst_n = 1'b1;
    #0.1;
    chk(!valid, "R1 post-release valid", {31'b0, valid}, 32'h0);
    chk(addr == 32'h0, "R1 post-release addr", addr, 32'h0);
    exp_pc = 32'h0; exp_fetch = 32'h0; bubble_left = 1;
    h_instr = instr; h_pc = pc; h_valid = valid;

    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, '0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, '0);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b1, 32'h0000_0203);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, '0);

    // all stall/redirect combinations over three cycles
    for (int p = 0; p < 64; p++) begin
      for (int k = 0; k < 3; k++) begin
        cyc(p[2*k], p[2*k+1], 32'h0000_1000 + 32'(p) * 32'h40 + 32'(k));
      end
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule